// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block is a small data cache placed between a processor-side request port and a lower-level memory port. Each cached block is one data word. A byte address is divided into three fields: the byte offset within the word, a set index and a tag. Lookup compares the stored tags of every way in the indexed set in the same cycle as the request is presented. A hit completes one cycle after acceptance. A miss holds the request port not-ready while the block is fetched over the memory port.

The write policy is fixed when the block is built. In write-back mode, stores update only the cache and mark the line dirty. A dirty victim is written out before its frame is refilled, and a write miss first fetches the block and then merges the stored bytes into it. In write-through mode, every store is queued in a small write buffer that drains to memory one entry per cycle, so stores never wait on memory. Write misses do not allocate a line. A read miss waits until the buffer is empty before it goes out. Victim choice is also fixed at build time: either least-recently-used with one marker bit per set, or a pseudo-random pick from a free-running LFSR.

The memory side is a request/response port that accepts a request every cycle. It answers a read after a fixed latency with a one-cycle response strobe. Writes carry byte enables and return no response.

Top module: `cache_ctl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. The first read of any address therefore misses.
- R2: Address bits [1:0] are the byte offset. The set index is the block number (address >> 2) modulo SETS, and the tag is the remaining upper bits. Only the tag is compared. With the default 4 sets by 2 ways, block 12 falls in set 0 together with blocks 20, 28, 36 and 44, and block 13 falls in set 1.
- R3: A read hit raises `rsp_valid` with the cached data in the cycle after acceptance and issues no memory request.
- R4: A read miss drops `req_ready` until it completes. It issues one memory read of the block address and returns the fetched word with `rsp_valid` after the memory response.
- R5: On a miss, the lowest-numbered invalid way is the victim. When no way is invalid, the victim is the least-recently-used way when REPL_LRU=1, with the marker updated on every hit and every refill. When REPL_LRU=0, the victim comes from an LFSR.
- R6: In write-back mode, a write hit merges the bytes selected by `req_be` (bit i selects data bits 8i+7:8i) into the line, sets its dirty bit, completes the cycle after acceptance and issues no memory request.
- R7: In write-back mode, a dirty victim is written to memory, full word at its own address, before the refill read. A clean victim causes no memory write.
- R8: In write-back mode, a write miss fetches the block, merges the write into it and leaves the line dirty without writing memory.
- R9: In write-through mode, each accepted write produces exactly one memory write with the same address, data and byte enables. A write hit also updates the cached line. A write miss allocates no line.
- R10: In write-through mode, writes complete the cycle after acceptance whatever the memory is doing. Buffered writes reach memory in acceptance order, and `req_ready` drops only while the buffer is full.
- R11: In write-through mode, a read miss issues its memory read only once the write buffer is empty. It never writes a victim to memory and returns the most recent stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted when both valid and ready |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Load data, valid with rsp_valid on loads |
| mem_req_valid | output | 1 | Memory request, always accepted |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Word-aligned memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_req_be | output | DATA_W/8 | Memory write byte enables |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | DATA_W | Read response data |

## Verification
Several properties are checked on every cycle. An accepted hit answers on the next cycle. No address matches two ways of a set. A write-back store hit creates no memory traffic. A write-through store always leaves an entry queued. A write-through memory read only leaves with an empty buffer. An accepted miss drops `req_ready`. The bench scenarios cover what the per-cycle properties cannot show: which blocks share a set, the least-recently-used eviction order, byte merging on hits and on allocating misses, the timing of dirty write-back, no-allocate on a write-through store miss, and the last-written value winning through the buffer.

// File: rtl/cache_ctl.sv
module cache_ctl #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int WRITE_BACK = 1,
  parameter int REPL_LRU   = 1,
  parameter int WBUF_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_req_valid,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_rdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);
  localparam int IDX_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PTR_W = (WBUF_DEPTH > 1) ? $clog2(WBUF_DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam bit WB    = (WRITE_BACK != 0);

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_DRAIN, S_FILL, S_WAIT} state_t;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_d,
                                              input logic [DATA_W-1:0] new_d,
                                              input logic [BE_W-1:0]   be);
    for (int b = 0; b < BE_W; b++)
      merge[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
  endfunction

  state_t             state;
  logic [WAYS-1:0]    vld_q   [SETS];
  logic [WAYS-1:0]    dirty_q [SETS];
  logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
  logic [DATA_W-1:0]  dat_q   [SETS][WAYS];
  logic [SETS-1:0]    lru_q;
  logic [7:0]         lfsr_q;

  logic [BLK_W-1:0]   m_blk;
  logic               m_write;
  logic [DATA_W-1:0]  m_wdata;
  logic [BE_W-1:0]    m_be;
  logic [WAY_W-1:0]   m_way;

  logic [BLK_W-1:0]   wb_addr [WBUF_DEPTH];
  logic [DATA_W-1:0]  wb_data [WBUF_DEPTH];
  logic [BE_W-1:0]    wb_be   [WBUF_DEPTH];
  logic [PTR_W-1:0]   wr_p, rd_p;
  logic [CNT_W-1:0]   wcnt;

  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] m_idx = m_blk[IDX_W-1:0];
  wire [TAG_W-1:0] m_tag = m_blk[BLK_W-1 -: TAG_W];
  wire unused_off = ^req_addr[OFF_W-1:0];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, inv_way, victim;
  logic             has_inv;

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    has_inv = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[r_idx][w] && (tag_q[r_idx][w] == r_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[r_idx][w]) begin
        has_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    victim = has_inv ? inv_way
           : (REPL_LRU != 0) ? WAY_W'(lru_q[r_idx]) : lfsr_q[WAY_W-1:0];
  end

  wire hit    = |hit_vec;
  assign req_ready = (state == S_IDLE) && (wcnt != CNT_W'(WBUF_DEPTH));
  wire accept = req_valid && req_ready;
  wire hit_wr = accept && hit && req_write;
  wire push   = !WB && accept && req_write;
  wire pop    = !WB && (wcnt != '0);
  wire fill   = (state == S_WAIT) && mem_rsp_valid;
  wire [DATA_W-1:0] fill_data = m_write ? merge(mem_rsp_rdata, m_wdata, m_be) : mem_rsp_rdata;

  assign mem_req_valid = pop || (state == S_EVICT) || (state == S_FILL);
  assign mem_req_write = pop || (state == S_EVICT);
  assign mem_req_addr  = pop ? {wb_addr[rd_p], {OFF_W{1'b0}}}
                       : (state == S_EVICT) ? {tag_q[m_idx][m_way], m_idx, {OFF_W{1'b0}}}
                       : {m_blk, {OFF_W{1'b0}}};
  assign mem_req_wdata = pop ? wb_data[rd_p] : dat_q[m_idx][m_way];
  assign mem_req_be    = pop ? wb_be[rd_p] : '1;

  always_ff @(posedge clk) begin
    if (hit_wr)
      dat_q[r_idx][hit_way] <= merge(dat_q[r_idx][hit_way], req_wdata, req_be);
    if (fill) begin
      dat_q[m_idx][m_way] <= fill_data;
      tag_q[m_idx][m_way] <= m_tag;
    end
    if (push) begin
      wb_addr[wr_p] <= req_addr[ADDR_W-1:OFF_W];
      wb_data[wr_p] <= req_wdata;
      wb_be[wr_p]   <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lru_q     <= '0;
      lfsr_q    <= 8'h01;
      m_blk     <= '0;
      m_write   <= 1'b0;
      m_wdata   <= '0;
      m_be      <= '0;
      m_way     <= '0;
      wr_p      <= '0;
      rd_p      <= '0;
      wcnt      <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      lfsr_q    <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
      rsp_valid <= 1'b0;
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
      wcnt <= wcnt + CNT_W'(push) - CNT_W'(pop);
      case (state)
        S_IDLE: if (accept) begin
          m_blk   <= req_addr[ADDR_W-1:OFF_W];
          m_write <= req_write;
          m_wdata <= req_wdata;
          m_be    <= req_be;
          m_way   <= victim;
          if (hit) begin
            rsp_valid      <= 1'b1;
            rsp_rdata      <= dat_q[r_idx][hit_way];
            lru_q[r_idx]   <= ~hit_way[0];
            if (req_write && WB) dirty_q[r_idx][hit_way] <= 1'b1;
          end else if (req_write && !WB) begin
            rsp_valid <= 1'b1;
          end else begin
            state <= (WB && vld_q[r_idx][victim] && dirty_q[r_idx][victim]) ? S_EVICT : S_DRAIN;
          end
        end
        S_EVICT: state <= S_DRAIN;
        S_DRAIN: if (wcnt == '0) state <= S_FILL;
        S_FILL:  state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          vld_q[m_idx][m_way]   <= 1'b1;
          dirty_q[m_idx][m_way] <= WB && m_write;
          lru_q[m_idx]          <= ~m_way[0];
          rsp_valid             <= 1'b1;
          rsp_rdata             <= fill_data;
          state                 <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk #(
  parameter int WAYS       = 2,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             hit,
  input logic [WAYS-1:0]  hit_vec,
  input logic             req_write,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_write,
  input logic [CNT_W-1:0] wcnt
);
  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid);

  // R2
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  wb_quiet_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK != 0) && accept && hit && req_write |=> !mem_req_valid);

  // R10
  wt_store_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 0) && accept && req_write |=> wcnt != '0);

  // R11
  wt_read_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 0) && mem_req_valid && !mem_req_write |-> wcnt == '0);

  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit && !(WRITE_BACK == 0 && req_write) |=> !req_ready);
endmodule

bind cache_ctl cache_ctl_chk #(.WAYS(WAYS), .WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit), .hit_vec(hit_vec),
  .req_write(req_write), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .wcnt(wcnt)
);

// File: tb/test_cache_ctl.sv
module mem_model #(parameter int LAT = 3) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output int          n_rd,
  output int          n_wr
);
  logic [31:0] mem [256];
  logic        busy;
  int          cd;
  logic [7:0]  ra;

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;

  assign rsp_valid = busy && (cd == 1);
  assign rsp_rdata = mem[ra];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cd <= 0; ra <= '0; n_rd <= 0; n_wr <= 0;
    end else if (req_valid) begin
      if (req_write) begin
        for (int b = 0; b < 4; b++)
          if (req_be[b]) mem[req_addr[9:2]][b*8 +: 8] <= req_wdata[b*8 +: 8];
        n_wr <= n_wr + 1;
      end else begin
        busy <= 1'b1; cd <= LAT; ra <= req_addr[9:2]; n_rd <= n_rd + 1;
      end
    end else if (busy) begin
      cd <= cd - 1;
      if (cd == 1) busy <= 1'b0;
    end
  end
endmodule

module test_cache_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic        a_valid = 0, a_write = 0, b_valid = 0, b_write = 0;
  logic [11:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [3:0]  a_be = 0, b_be = 0;
  logic        a_ready, a_rsp, b_ready, b_rsp;
  logic [31:0] a_rdata, b_rdata;
  logic        am_v, am_w, am_rv, bm_v, bm_w, bm_rv;
  logic [11:0] am_a, bm_a;
  logic [31:0] am_d, am_rd, bm_d, bm_rd;
  logic [3:0]  am_be, bm_be;
  int          a_nrd, a_nwr, b_nrd, b_nwr;

  logic [31:0] ref_a [256];
  logic [31:0] ref_b [256];

  cache_ctl #(.WRITE_BACK(1), .REPL_LRU(1)) i_cache_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
    .req_write(a_write), .req_addr(a_addr), .req_wdata(a_wdata), .req_be(a_be),
    .rsp_valid(a_rsp), .rsp_rdata(a_rdata), .mem_req_valid(am_v), .mem_req_write(am_w),
    .mem_req_addr(am_a), .mem_req_wdata(am_d), .mem_req_be(am_be),
    .mem_rsp_valid(am_rv), .mem_rsp_rdata(am_rd));

  cache_ctl #(.WRITE_BACK(0), .REPL_LRU(0)) i_cache_ctl_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata), .req_be(b_be),
    .rsp_valid(b_rsp), .rsp_rdata(b_rdata), .mem_req_valid(bm_v), .mem_req_write(bm_w),
    .mem_req_addr(bm_a), .mem_req_wdata(bm_d), .mem_req_be(bm_be),
    .mem_rsp_valid(bm_rv), .mem_rsp_rdata(bm_rd));

  mem_model i_mem_a (.clk(clk), .rst_n(rst_n), .req_valid(am_v), .req_write(am_w),
    .req_addr(am_a), .req_wdata(am_d), .req_be(am_be), .rsp_valid(am_rv),
    .rsp_rdata(am_rd), .n_rd(a_nrd), .n_wr(a_nwr));
  mem_model i_mem_b (.clk(clk), .rst_n(rst_n), .req_valid(bm_v), .req_write(bm_w),
    .req_addr(bm_a), .req_wdata(bm_d), .req_be(bm_be), .rsp_valid(bm_rv),
    .rsp_rdata(bm_rd), .n_rd(b_nrd), .n_wr(b_nwr));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) o[b*8 +: 8] = n[b*8 +: 8];
    return o;
  endfunction

  // called at a negedge; returns at the negedge where the response is seen
  task automatic xfer(bit wt, bit wr, int blk, logic [31:0] d, logic [3:0] be,
                      output logic [31:0] rd, output int lat);
    if (wt) begin b_valid = 1; b_write = wr; b_addr = 12'(blk * 4); b_wdata = d; b_be = be; end
    else    begin a_valid = 1; a_write = wr; a_addr = 12'(blk * 4); a_wdata = d; a_be = be; end
    while (!(wt ? b_ready : a_ready)) @(negedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    lat = 0;
    while (!(wt ? b_rsp : a_rsp)) begin @(negedge clk); lat++; end
    rd = wt ? b_rdata : a_rdata;
    if (wr) begin
      if (wt) ref_b[blk] = mrg(ref_b[blk], d, be);
      else    ref_a[blk] = mrg(ref_a[blk], d, be);
    end
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", 32'(a_ready), 1);
    chk("R1 no response after reset", 32'(a_rsp), 0);
    chk("R1 no memory request after reset", 32'(am_v), 0);
    chk("R1 wt ready after reset", 32'(b_ready), 1);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] rd; int lat; int r0 = a_nrd;
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R1 first read misses", 32'(a_nrd - r0), 1);
    chk("R4 miss data", rd, ref_a[12]);
    chk("R4 miss stalls", 32'(lat != 0), 1);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R3 hit next cycle", 32'(lat), 0);
    chk("R3 hit no memory read", 32'(a_nrd - r0), 1);
    chk("R3 hit data", rd, ref_a[12]);
  endtask

  task automatic t_mapping_lru();
    logic [31:0] rd; int lat; int r0 = a_nrd;
    xfer(0, 0, 20, 0, 0, rd, lat);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R5 invalid way filled first, block 12 kept", 32'(a_nrd - r0), 1);
    xfer(0, 0, 13, 0, 0, rd, lat);
    xfer(0, 0, 20, 0, 0, rd, lat);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R2 block 13 outside set 0", 32'(a_nrd - r0), 2);
    chk("R2 block 12 data", rd, ref_a[12]);
    xfer(0, 0, 28, 0, 0, rd, lat);
    chk("R2 block 28 tag-only compare miss", 32'(a_nrd - r0), 3);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R5 most recent block kept", 32'(a_nrd - r0), 3);
    xfer(0, 0, 20, 0, 0, rd, lat);
    chk("R5 least recent block evicted", 32'(a_nrd - r0), 4);
    chk("R5 refetched data", rd, ref_a[20]);
  endtask

  task automatic t_wb_write_hit();
    logic [31:0] rd; int lat; int r0 = a_nrd; int w0 = a_nwr;
    xfer(0, 1, 12, 32'h1122_3344, 4'b0101, rd, lat);
    chk("R6 store hit next cycle", 32'(lat), 0);
    repeat (3) @(negedge clk);
    chk("R6 store hit no memory write", 32'(a_nwr - w0), 0);
    chk("R6 memory untouched", i_mem_a.mem[12], 32'hA500_000C);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R6 merged bytes", rd, ref_a[12]);
    chk("R6 no memory read", 32'(a_nrd - r0), 0);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int lat; int w0 = a_nwr;
    xfer(0, 0, 36, 0, 0, rd, lat);
    chk("R7 clean victim not written", 32'(a_nwr - w0), 0);
    xfer(0, 0, 44, 0, 0, rd, lat);
    chk("R7 dirty victim written once", 32'(a_nwr - w0), 1);
    chk("R7 written value", i_mem_a.mem[12], ref_a[12]);
    xfer(0, 0, 12, 0, 0, rd, lat);
    chk("R7 refetch after eviction", rd, ref_a[12]);
  endtask

  task automatic t_wb_write_miss();
    logic [31:0] rd; int lat; int r0 = a_nrd; int w0 = a_nwr;
    xfer(0, 1, 52, 32'hDEAD_BEEF, 4'b1100, rd, lat);
    chk("R8 store miss fetches", 32'(a_nrd - r0), 1);
    chk("R8 store miss no memory write", 32'(a_nwr - w0), 0);
    chk("R8 memory untouched", i_mem_a.mem[52], 32'hA500_0034);
    xfer(0, 0, 52, 0, 0, rd, lat);
    chk("R8 merged line hits", 32'(a_nrd - r0), 1);
    chk("R8 merged data", rd, ref_a[52]);
  endtask

  task automatic t_wt_write();
    logic [31:0] rd; int lat; int r0 = b_nrd; int w0 = b_nwr;
    xfer(1, 1, 5, 32'h0BAD_F00D, 4'b1111, rd, lat);
    chk("R10 store completes next cycle", 32'(lat), 0);
    repeat (2) @(negedge clk);
    chk("R9 one memory write", 32'(b_nwr - w0), 1);
    chk("R9 memory value", i_mem_b.mem[5], ref_b[5]);
    xfer(1, 0, 5, 0, 0, rd, lat);
    chk("R9 store miss not allocated", 32'(b_nrd - r0), 1);
    chk("R9 read returns stored value", rd, ref_b[5]);
    xfer(1, 1, 5, 32'h7777_5555, 4'b0011, rd, lat);
    xfer(1, 0, 5, 0, 0, rd, lat);
    chk("R9 store hit updates line", rd, ref_b[5]);
    chk("R9 store hit read no memory read", 32'(b_nrd - r0), 1);
    repeat (2) @(negedge clk);
    chk("R9 store hit written through", i_mem_b.mem[5], ref_b[5]);
  endtask

  task automatic t_wt_stream();
    logic [31:0] rd; int lat; int w0 = b_nwr; int lsum = 0;
    xfer(1, 1, 6, 32'h6666_6666, 4'hF, rd, lat); lsum += lat;
    xfer(1, 1, 7, 32'h7070_7070, 4'hF, rd, lat); lsum += lat;
    xfer(1, 1, 9, 32'h1111_1111, 4'hF, rd, lat); lsum += lat;
    xfer(1, 1, 9, 32'h2222_2222, 4'hF, rd, lat); lsum += lat;
    chk("R10 back-to-back stores never wait", 32'(lsum), 0);
    repeat (4) @(negedge clk);
    chk("R10 all stores reached memory", 32'(b_nwr - w0), 4);
    chk("R10 order kept, last value wins", i_mem_b.mem[9], 32'h2222_2222);
    chk("R9 block 7 written", i_mem_b.mem[7], ref_b[7]);
  endtask

  task automatic t_wt_read_drain();
    logic [31:0] rd; int lat; int w0 = b_nwr;
    xfer(1, 1, 10, 32'hCAFE_0010, 4'hF, rd, lat);
    xfer(1, 0, 10, 0, 0, rd, lat);
    chk("R11 read after queued store", rd, 32'hCAFE_0010);
    chk("R11 no victim write", 32'(b_nwr - w0), 1);
  endtask

  task automatic t_wt_random();
    logic [31:0] rd; int lat; int r0 = b_nrd;
    xfer(1, 0, 12, 0, 0, rd, lat);
    xfer(1, 0, 20, 0, 0, rd, lat);
    xfer(1, 0, 12, 0, 0, rd, lat);
    chk("R5 random mode fills invalid way first", 32'(b_nrd - r0), 2);
    xfer(1, 0, 28, 0, 0, rd, lat);
    xfer(1, 0, 28, 0, 0, rd, lat);
    chk("R5 random victim refill hits", 32'(b_nrd - r0), 3);
    chk("R5 random refill data", rd, ref_b[28]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_a[i] = 32'hA500_0000 | i;
      ref_b[i] = 32'hA500_0000 | i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_mapping_lru();
    t_wb_write_hit();
    t_dirty_evict();
    t_wb_write_miss();
    t_wt_write();
    t_wt_stream();
    t_wt_read_drain();
    t_wt_random();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule